// File: doc/BRIEF.md
# Buffered Real-Time Calendar Register Bank

This block keeps wall-clock time and calendar date as seven BCD registers (seconds, minutes, hours, day of month, month, day of week, two-digit year) plus one general control byte, and advances them once per second on a one-cycle `sec_tick` pulse. The calendar knows each month's length and treats every year whose two BCD digits form a multiple of four as a leap year.

A byte-wide burst port gives access to the bank. A read burst freezes a snapshot of the seven time registers in the cycle it starts, so every byte it returns belongs to the same instant. A write burst fills a staging buffer and does not touch the running counters. Once all eight bytes are in and the burst ends cleanly, the staged time waits for the next second tick and is loaded on that tick in place of an increment. A short burst or an abort throws the buffer away. The control byte of a completed write takes effect as soon as the burst ends.

Top module: `rtcbank_top`

## Requirements
- R1: During and after reset, every read byte shows seconds 00, minutes 00, hours 00, date 01, month 01, weekday 01, year 00, control 00, and `commit_pending` is 0.
- R2: Each `sec_tick` with no commit pending advances the seconds register in BCD. 59 wraps to 00 and carries into minutes, minutes 59 wraps and carries into hours, and hours 23 wraps to 00 and carries into date and weekday. Without a tick the registers hold.
- R3: At the last day of the month the date wraps to 01 and the month advances. The last day is 28 for February (29 when the BCD year is a multiple of four), 30 for months 04, 06, 09 and 11, and 31 otherwise. Month 12 wraps to 01 and carries into the year, year 99 wraps to 00, and weekday 07 wraps to 01.
- R4: A burst returns bytes in the fixed order seconds, minutes, hours, date, month, weekday, year, control. Byte index 0 appears on `bus_rdata` in the cycle after the `bus_start` edge, and each `bus_valid` moves to the next index. Past index 7, and outside a read burst, `bus_rdata` is 00.
- R5: A read burst captures the seven time registers at its start. Ticks during the burst do not change the bytes it returns, but the live counters keep advancing.
- R6: Write-burst bytes go to a staging buffer. The live counters keep counting during a write, and a completed write is not visible in the time registers until it is committed.
- R7: A completed write sets `commit_pending`. On the next tick the staged time replaces the counters instead of incrementing them, `commit_pending` clears, and the tick after that increments from the loaded value.
- R8: A write ended by `bus_end` with fewer than eight bytes, or ended by `bus_abort`, leaves the time, the control byte and `commit_pending` unchanged.
- R9: If a write completes in the same cycle as a tick, that tick acts on the old state (increment, or load of an earlier pending value), and the new value loads on the following tick.
- R10: Data bytes beyond the eighth in one write burst are ignored, and the burst still counts as complete.
- R11: The control byte of a completed write is readable in the cycle after `bus_end`, without waiting for a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse marking the rising edge of the 1 Hz clock |
| bus_start | input | 1 | Begins a burst. Ignored in a cycle that also has `bus_end` or `bus_abort` |
| bus_wr | input | 1 | Direction sampled with `bus_start`: 1 for a write, 0 for a read |
| bus_valid | input | 1 | Accepts `bus_wdata` (write) or moves to the next byte (read). Ignored when `bus_start`, `bus_end` or `bus_abort` is high |
| bus_wdata | input | 8 | Write data byte |
| bus_end | input | 1 | Closes the burst. A write is complete only if eight bytes were taken |
| bus_abort | input | 1 | Closes the burst and discards any staged write. Overrides `bus_end` |
| bus_rdata | output | 8 | Read byte at the current burst index |
| commit_pending | output | 1 | A completed write is waiting for the next tick |

## Verification
The bench targets the second edge around a write. A write that completes on the tick cycle must load one tick later, not on that tick, and a design that loaded it at once would lose the increment that tick owes. A staged write must also skip exactly one increment when it loads, and a design that both loaded and counted would show seconds one too high. The calendar wraps are run at 28 February in a leap year and in a common year, at 30 April and at 31 December 99, so a wrong leap test or month table shows up as a wrong date. Short writes, aborted writes, writes of more than eight bytes and ticks in the middle of a read burst expose a buffer that leaks into the counters, a counter that does not saturate, or a snapshot that follows the live time.

// File: rtl/rtcbank_pkg.sv
package rtcbank_pkg;

    parameter int BYTE_W   = 8;
    parameter int NIB_W    = 4;
    parameter int NUM_TIME = 7;
    localparam int NUM_REG = NUM_TIME + 1;
    localparam int IDX_W   = $clog2(NUM_REG);
    localparam int CNT_W   = IDX_W + 1;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    localparam cnt_t CNT_FULL = cnt_t'(NUM_REG);

    // Field order is burst order: seconds occupy the low byte.
    typedef enum logic [IDX_W-1:0] {
        F_SEC  = 3'd0,
        F_MIN  = 3'd1,
        F_HR   = 3'd2,
        F_DATE = 3'd3,
        F_MON  = 3'd4,
        F_DOW  = 3'd5,
        F_YR   = 3'd6,
        F_CTRL = 3'd7
    } field_e;

    typedef struct packed {
        byte_t yr;
        byte_t dow;
        byte_t mon;
        byte_t date;
        byte_t hr;
        byte_t min;
        byte_t sec;
    } clock_t;

    localparam clock_t CLOCK_RST = '{
        yr: 8'h00, dow: 8'h01, mon: 8'h01, date: 8'h01,
        hr: 8'h00, min: 8'h00, sec: 8'h00
    };

    function automatic byte_t bcd_step(input byte_t v);
        byte_t r;
        if (v[NIB_W-1:0] == 4'h9)
            r = {v[BYTE_W-1:NIB_W] + 4'h1, 4'h0};
        else
            r = v + byte_t'(1);
        return r;
    endfunction

    function automatic logic bcd_leap(input byte_t yr);
        logic [NIB_W-1:0] hi, lo;
        hi = yr[BYTE_W-1:NIB_W];
        lo = yr[NIB_W-1:0];
        if (hi[0])
            return (lo == 4'h2) || (lo == 4'h6);
        else
            return (lo == 4'h0) || (lo == 4'h4) || (lo == 4'h8);
    endfunction

    function automatic byte_t month_last(input byte_t mon, input byte_t yr);
        byte_t r;
        case (mon)
            8'h02:                      r = bcd_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
            default:                    r = 8'h31;
        endcase
        return r;
    endfunction

    function automatic clock_t clock_next(input clock_t t);
        clock_t n;
        n = t;
        if (t.sec != 8'h59) begin
            n.sec = bcd_step(t.sec);
        end else begin
            n.sec = 8'h00;
            if (t.min != 8'h59) begin
                n.min = bcd_step(t.min);
            end else begin
                n.min = 8'h00;
                if (t.hr != 8'h23) begin
                    n.hr = bcd_step(t.hr);
                end else begin
                    n.hr  = 8'h00;
                    n.dow = (t.dow == 8'h07) ? 8'h01 : bcd_step(t.dow);
                    if (t.date != month_last(t.mon, t.yr)) begin
                        n.date = bcd_step(t.date);
                    end else begin
                        n.date = 8'h01;
                        if (t.mon != 8'h12) begin
                            n.mon = bcd_step(t.mon);
                        end else begin
                            n.mon = 8'h01;
                            n.yr  = (t.yr == 8'h99) ? 8'h00 : bcd_step(t.yr);
                        end
                    end
                end
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/rtcbank_clock.sv
module rtcbank_clock
    import rtcbank_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   load,
    input  clock_t load_val,
    output clock_t now
);

    always_ff @(posedge clk) begin
        if (rst)
            now <= CLOCK_RST;
        else if (tick)
            now <= load ? load_val : clock_next(now);
    end

endmodule

// File: rtl/rtcbank_access.sv
module rtcbank_access
    import rtcbank_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sec_tick,
    input  logic   bus_start,
    input  logic   bus_wr,
    input  logic   bus_valid,
    input  byte_t  bus_wdata,
    input  logic   bus_end,
    input  logic   bus_abort,
    output logic   rd_active,
    output cnt_t   rd_idx,
    output logic   rd_capture,
    output logic   wr_done,
    output clock_t stage,
    output logic   pend,
    output byte_t  ctrl
);

    logic   active_q, is_wr_q;
    cnt_t   cnt_q;
    byte_t  buf_q [NUM_REG];
    clock_t buf_clock;
    logic   begin_ok, step_ok;

    for (genvar g = 0; g < NUM_TIME; g++) begin : g_pack
        assign buf_clock[g*BYTE_W +: BYTE_W] = buf_q[g];
    end

    always_comb begin
        begin_ok   = bus_start & ~bus_end & ~bus_abort;
        step_ok    = bus_valid & ~bus_start & ~bus_end & ~bus_abort
                     & active_q & (cnt_q < CNT_FULL);
        rd_capture = begin_ok & ~bus_wr;
        wr_done    = active_q & is_wr_q & bus_end & ~bus_abort
                     & (cnt_q == CNT_FULL);
        rd_active  = active_q & ~is_wr_q;
        rd_idx     = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            is_wr_q  <= 1'b0;
            cnt_q    <= '0;
            for (int i = 0; i < NUM_REG; i++) buf_q[i] <= '0;
        end else begin
            if (bus_abort || bus_end) begin
                active_q <= 1'b0;
            end else if (begin_ok) begin
                active_q <= 1'b1;
                is_wr_q  <= bus_wr;
                cnt_q    <= '0;
            end else if (step_ok) begin
                if (is_wr_q) buf_q[cnt_q[IDX_W-1:0]] <= bus_wdata;
                cnt_q <= cnt_q + cnt_t'(1);
            end
        end
    end

    // Staged value and pending flag: a completion wins over a tick clear.
    always_ff @(posedge clk) begin
        if (rst) begin
            pend  <= 1'b0;
            stage <= CLOCK_RST;
            ctrl  <= '0;
        end else if (wr_done) begin
            pend  <= 1'b1;
            stage <= buf_clock;
            ctrl  <= buf_q[F_CTRL];
        end else if (sec_tick) begin
            pend  <= 1'b0;
        end
    end

endmodule

// File: rtl/rtcbank_snap.sv
module rtcbank_snap
    import rtcbank_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   capture,
    input  clock_t live,
    input  byte_t  ctrl,
    input  logic   rd_active,
    input  cnt_t   rd_idx,
    output byte_t  rdata
);

    clock_t snap_q;
    byte_t  lanes [NUM_REG];

    always_ff @(posedge clk) begin
        if (rst)
            snap_q <= CLOCK_RST;
        else if (capture)
            snap_q <= live;
    end

    for (genvar g = 0; g < NUM_TIME; g++) begin : g_lane
        assign lanes[g] = snap_q[g*BYTE_W +: BYTE_W];
    end
    assign lanes[F_CTRL] = ctrl;

    always_comb begin
        if (rd_active && (rd_idx < CNT_FULL))
            rdata = lanes[rd_idx[IDX_W-1:0]];
        else
            rdata = '0;
    end

endmodule

// File: rtl/rtcbank_top.sv
module rtcbank_top
    import rtcbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sec_tick,
    input  logic              bus_start,
    input  logic              bus_wr,
    input  logic              bus_valid,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic              bus_end,
    input  logic              bus_abort,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              commit_pending
);

    clock_t live_t, stage_t;
    byte_t  ctrl_b;
    logic   rd_active, rd_capture, wr_done, pend;
    cnt_t   rd_idx;

    rtcbank_access u_access (
        .clk        (clk),
        .rst        (rst),
        .sec_tick   (sec_tick),
        .bus_start  (bus_start),
        .bus_wr     (bus_wr),
        .bus_valid  (bus_valid),
        .bus_wdata  (bus_wdata),
        .bus_end    (bus_end),
        .bus_abort  (bus_abort),
        .rd_active  (rd_active),
        .rd_idx     (rd_idx),
        .rd_capture (rd_capture),
        .wr_done    (wr_done),
        .stage      (stage_t),
        .pend       (pend),
        .ctrl       (ctrl_b)
    );

    rtcbank_clock u_clock (
        .clk      (clk),
        .rst      (rst),
        .tick     (sec_tick),
        .load     (pend),
        .load_val (stage_t),
        .now      (live_t)
    );

    rtcbank_snap u_snap (
        .clk       (clk),
        .rst       (rst),
        .capture   (rd_capture),
        .live      (live_t),
        .ctrl      (ctrl_b),
        .rd_active (rd_active),
        .rd_idx    (rd_idx),
        .rdata     (bus_rdata)
    );

    assign commit_pending = pend;

endmodule

// File: rtl/rtcbank_chk.sv
module rtcbank_chk
    import rtcbank_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sec_tick,
    input  logic   bus_start,
    input  logic   bus_valid,
    input  logic   bus_end,
    input  logic   bus_abort,
    input  byte_t  bus_rdata,
    input  logic   commit_pending,
    input  logic   wr_done,
    input  logic   rd_active,
    input  clock_t live_t,
    input  clock_t stage_t
);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!commit_pending && live_t == CLOCK_RST));

    assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (rst)
        !sec_tick |=> $stable(live_t));

    assert_snapshot_frozen_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_active && !bus_start && !bus_valid && !bus_end && !bus_abort)
        |=> $stable(bus_rdata));

    assert_commit_loads_R7: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && commit_pending) |=> (live_t == $past(stage_t)));

    assert_pending_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && !wr_done) |=> !commit_pending);

    assert_abort_no_pending_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_abort && !commit_pending) |=> !commit_pending);

    assert_collision_defers_R9: assert property (@(posedge clk) disable iff (rst)
        wr_done |=> commit_pending);

endmodule

bind rtcbank_top rtcbank_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .sec_tick       (sec_tick),
    .bus_start      (bus_start),
    .bus_valid      (bus_valid),
    .bus_end        (bus_end),
    .bus_abort      (bus_abort),
    .bus_rdata      (bus_rdata),
    .commit_pending (commit_pending),
    .wr_done        (wr_done),
    .rd_active      (rd_active),
    .live_t         (live_t),
    .stage_t        (stage_t)
);

// File: tb/sim_rtcbank_top.sv
module sim_rtcbank_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sec_tick = 1'b0;
    logic       bus_start = 1'b0, bus_wr = 1'b0, bus_valid = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_end = 1'b0, bus_abort = 1'b0;
    logic [7:0] bus_rdata;
    logic       commit_pending;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    rtcbank_top u0 (
        .clk(clk), .rst(rst), .sec_tick(sec_tick),
        .bus_start(bus_start), .bus_wr(bus_wr), .bus_valid(bus_valid),
        .bus_wdata(bus_wdata), .bus_end(bus_end), .bus_abort(bus_abort),
        .bus_rdata(bus_rdata), .commit_pending(commit_pending)
    );

    // ---------------- behavioural reference model ----------------
    int         m_t [7];
    int         m_snap [7];
    logic [7:0] m_stage [7];
    logic [7:0] m_buf [8];
    logic [7:0] m_ctrl;
    bit         m_pend, m_act, m_wr;
    int         m_cnt;

    function automatic logic [7:0] to_bcd(input int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    function automatic int from_bcd(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic int days_of(input int mon, input int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    task automatic model_reset();
        m_t = '{0, 0, 0, 1, 1, 1, 0};
        m_snap = m_t;
        m_ctrl = 8'h00; m_pend = 0; m_act = 0; m_wr = 0; m_cnt = 0;
    endtask

    task automatic model_advance();
        m_t[0]++;
        if (m_t[0] < 60) return;
        m_t[0] = 0; m_t[1]++;
        if (m_t[1] < 60) return;
        m_t[1] = 0; m_t[2]++;
        if (m_t[2] < 24) return;
        m_t[2] = 0;
        m_t[5] = (m_t[5] == 7) ? 1 : m_t[5] + 1;
        if (m_t[3] < days_of(m_t[4], m_t[6])) begin m_t[3]++; return; end
        m_t[3] = 1;
        if (m_t[4] < 12) begin m_t[4]++; return; end
        m_t[4] = 1;
        m_t[6] = (m_t[6] + 1) % 100;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            model_reset();
        end else begin
            bit done;
            int old_t [7];
            old_t = m_t;
            done = m_act && m_wr && bus_end && !bus_abort && (m_cnt == 8);
            if (sec_tick) begin
                if (m_pend) for (int i = 0; i < 7; i++) m_t[i] = from_bcd(m_stage[i]);
                else model_advance();
            end
            if (done) begin
                m_pend = 1;
                for (int i = 0; i < 7; i++) m_stage[i] = m_buf[i];
                m_ctrl = m_buf[7];
            end else if (sec_tick) begin
                m_pend = 0;
            end
            if (bus_abort || bus_end) begin
                m_act = 0;
            end else if (bus_start) begin
                m_act = 1; m_wr = bus_wr; m_cnt = 0;
                if (!bus_wr) m_snap = old_t;
            end else if (bus_valid && m_act && m_cnt < 8) begin
                if (m_wr) m_buf[m_cnt] = bus_wdata;
                m_cnt++;
            end
        end
    end

    function automatic logic [7:0] model_rdata();
        if (!m_act || m_wr || m_cnt >= 8) return 8'h00;
        if (m_cnt == 7) return m_ctrl;
        return to_bcd(m_snap[m_cnt]);
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // Per-clock comparison against the model (R4 read path, R7 pending flag).
    always @(negedge clk) begin
        if (!rst) begin
            chk("R4 rdata vs model", bus_rdata, model_rdata());
            chk("R7 pending vs model", {7'b0, commit_pending}, {7'b0, m_pend});
        end
    end

    // ---------------- stimulus helpers ----------------
    logic [7:0] rb [8];
    logic [7:0] wb [10];

    task automatic do_tick(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk) sec_tick = 1'b1;
            @(negedge clk) sec_tick = 1'b0;
        end
    endtask

    task automatic read_all(input int tick_a, input int tick_b);
        @(negedge clk) begin bus_start = 1'b1; bus_wr = 1'b0; end
        @(negedge clk) bus_start = 1'b0;
        for (int i = 0; i < 8; i++) begin
            rb[i] = bus_rdata;
            bus_valid = 1'b1;
            if (i == tick_a || i == tick_b) sec_tick = 1'b1;
            @(negedge clk);
            bus_valid = 1'b0;
            sec_tick = 1'b0;
        end
        bus_end = 1'b1;
        @(negedge clk) bus_end = 1'b0;
    endtask

    task automatic write_n(input int n, input bit abort, input bit tick_end,
                           input int tick_a, input int tick_b);
        @(negedge clk) begin bus_start = 1'b1; bus_wr = 1'b1; end
        @(negedge clk) bus_start = 1'b0;
        for (int i = 0; i < n; i++) begin
            bus_wdata = wb[i];
            bus_valid = 1'b1;
            if (i == tick_a || i == tick_b) sec_tick = 1'b1;
            @(negedge clk);
            bus_valid = 1'b0;
            sec_tick = 1'b0;
        end
        if (abort) bus_abort = 1'b1; else bus_end = 1'b1;
        if (tick_end) sec_tick = 1'b1;
        @(negedge clk) begin bus_abort = 1'b0; bus_end = 1'b0; sec_tick = 1'b0; end
    endtask

    task automatic set_wb(input logic [7:0] a0, a1, a2, a3, a4, a5, a6, a7);
        wb = '{a0, a1, a2, a3, a4, a5, a6, a7, 8'hAA, 8'hBB};
    endtask

    task automatic expect_time(input string tag, input logic [7:0] e0, e1, e2, e3, e4, e5, e6);
        chk(tag, rb[0], e0); chk(tag, rb[1], e1); chk(tag, rb[2], e2);
        chk(tag, rb[3], e3); chk(tag, rb[4], e4); chk(tag, rb[5], e5);
        chk(tag, rb[6], e6);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset contents
        read_all(-1, -1);
        expect_time("R1 reset", 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
        chk("R1 reset ctrl", rb[7], 8'h00);
        chk("R1 reset pending", {7'b0, commit_pending}, 8'h00);

        // R2: second and minute carries
        do_tick(60);
        read_all(-1, -1);
        chk("R2 sec wrap", rb[0], 8'h00);
        chk("R2 min carry", rb[1], 8'h01);
        do_tick(3540);
        read_all(-1, -1);
        chk("R2 hour carry", rb[2], 8'h01);
        chk("R2 min wrap", rb[1], 8'h00);

        // R6/R11: staged write, old time still visible, control immediate
        set_wb(8'h58, 8'h59, 8'h23, 8'h28, 8'h02, 8'h07, 8'h24, 8'h5A);
        write_n(8, 0, 0, -1, -1);
        chk("R7 pending set", {7'b0, commit_pending}, 8'h01);
        read_all(-1, -1);
        chk("R6 old hour kept", rb[2], 8'h01);
        chk("R6 old sec kept", rb[0], 8'h00);
        chk("R11 ctrl now", rb[7], 8'h5A);

        // R7: load on tick, increment on the next one
        do_tick(1);
        chk("R7 pending cleared", {7'b0, commit_pending}, 8'h00);
        read_all(-1, -1);
        expect_time("R7 loaded", 8'h58, 8'h59, 8'h23, 8'h28, 8'h02, 8'h07, 8'h24);
        do_tick(1);
        read_all(-1, -1);
        chk("R7 next tick counts", rb[0], 8'h59);

        // R3: leap February, weekday wrap
        do_tick(1);
        read_all(-1, -1);
        expect_time("R3 leap feb", 8'h00, 8'h00, 8'h00, 8'h29, 8'h02, 8'h01, 8'h24);

        // R3: common February
        set_wb(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h03, 8'h23, 8'h5A);
        write_n(8, 0, 0, -1, -1);
        do_tick(2);
        read_all(-1, -1);
        chk("R3 common feb date", rb[3], 8'h01);
        chk("R3 common feb month", rb[4], 8'h03);

        // R3: year wrap
        set_wb(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h03, 8'h99, 8'h00);
        write_n(8, 0, 0, -1, -1);
        do_tick(2);
        read_all(-1, -1);
        expect_time("R3 year wrap", 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h04, 8'h00);

        // R3: thirty-day month
        set_wb(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h02, 8'h25, 8'h00);
        write_n(8, 0, 0, -1, -1);
        do_tick(2);
        read_all(-1, -1);
        chk("R3 april date", rb[3], 8'h01);
        chk("R3 april month", rb[4], 8'h05);

        // R5: snapshot frozen while ticks land mid-burst
        read_all(2, 5);
        chk("R5 snapshot sec", rb[0], 8'h00);
        chk("R5 snapshot min", rb[1], 8'h00);
        read_all(-1, -1);
        chk("R5 live kept counting", rb[0], 8'h02);

        // R8: short write, then aborted full write
        set_wb(8'h11, 8'h22, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08);
        write_n(5, 0, 0, -1, -1);
        chk("R8 short no pending", {7'b0, commit_pending}, 8'h00);
        do_tick(1);
        read_all(-1, -1);
        chk("R8 short discarded", rb[0], 8'h03);
        chk("R8 short ctrl kept", rb[7], 8'h00);
        write_n(8, 1, 0, -1, -1);
        chk("R8 abort no pending", {7'b0, commit_pending}, 8'h00);
        do_tick(1);
        read_all(-1, -1);
        chk("R8 abort discarded", rb[0], 8'h04);

        // R9: completion on a tick cycle defers the load
        set_wb(8'h40, 8'h10, 8'h05, 8'h15, 8'h06, 8'h02, 8'h25, 8'h00);
        write_n(8, 0, 1, -1, -1);
        chk("R9 pending after collision", {7'b0, commit_pending}, 8'h01);
        read_all(-1, -1);
        chk("R9 tick counted", rb[0], 8'h05);
        do_tick(1);
        read_all(-1, -1);
        expect_time("R9 later load", 8'h40, 8'h10, 8'h05, 8'h15, 8'h06, 8'h02, 8'h25);

        // R10: extra bytes ignored
        set_wb(8'h00, 8'h00, 8'h12, 8'h01, 8'h01, 8'h01, 8'h30, 8'h77);
        write_n(10, 0, 0, -1, -1);
        chk("R10 still complete", {7'b0, commit_pending}, 8'h01);
        do_tick(1);
        read_all(-1, -1);
        chk("R10 ctrl from eighth", rb[7], 8'h77);
        chk("R10 hour", rb[2], 8'h12);
        chk("R10 year", rb[6], 8'h30);

        // R6: counters run during a write
        write_n(3, 1, 0, 0, 2);
        read_all(-1, -1);
        chk("R6 ran during write", rb[0], 8'h02);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule